// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits between the host write bus and the program engine of a one-time-programmable memory controller. Each bus write presents an address and a data word on a single-cycle strobe. The decoder watches these writes for a two-write unlock prefix followed by a command byte. It then moves the controller into one of four outcomes: plain read mode, identification mode, a pending single-word program, or the launch of a streamed multi-word program.

For a single-word program, the write that follows the command carries the target. The decoder captures that address and data and gives the program engine a one-cycle start pulse. In identification mode the block returns fixed identification words for host reads, chosen by the two lowest read address bits. A program-enable qualifier gates all write decoding. While the program engine reports that it is busy, every write is disregarded.

Top module: `otp_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 1, id_mode is 0, and both start pulses are 0.
- R2: The unlock prefix is a write of data 0xAA to address 0x555 followed by a write of data 0x55 to address 0x2AA. While a prefix is partly received, both read_mode and id_mode are 0.
- R3: After the prefix, the next write to address 0x555 carries the command byte. The byte values are: 0xF0 returns to read mode, 0x90 enters identification mode, 0xA0 arms a word program, and 0x20 launches a streamed program. Every output flag is registered and changes on the clock edge that samples the accepting write.
- R4: A write that does not continue a valid sequence returns the decoder to read mode. This covers a wrong second write, a third write to another address, and an unknown command byte.
- R5: A single write with data 0xF0 to any address returns the decoder to read mode from any unlock or identification state.
- R6: Decoding compares only address bits 10:0 and data bits 7:0. All higher bits are ignored.
- R7: In the armed state, the next enabled write captures the full address and data on prog_addr and prog_data and raises start_word_prog for exactly one cycle. The decoder then returns to read mode.
- R8: The 0x20 command raises start_multi_prog for exactly one cycle and leaves the decoder in read mode.
- R9: Identification mode persists through every write other than a reset. The reset may be the single 0xF0 write or the full prefix followed by 0xF0.
- R10: In identification mode, id_rdata is 0x0020 when rd_addr[1:0]=00 and 0x888A when it is 01. For the other two values it is 0. It is 0 whenever id_mode is 0.
- R11: A write with prog_en low is ignored, with one exception. In the armed word-program state, such a write abandons the program: no start pulse is raised and the decoder returns to read mode.
- R12: A write while eng_busy is high is ignored, and that includes a reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 22 | Write address |
| wr_data | input | 16 | Write data |
| prog_en | input | 1 | Program-enable qualifier |
| eng_busy | input | 1 | Program engine running |
| rd_addr | input | 22 | Host read address |
| read_mode | output | 1 | Idle in read mode, no sequence pending |
| id_mode | output | 1 | Identification mode active |
| start_word_prog | output | 1 | One-cycle single-word program start |
| start_multi_prog | output | 1 | One-cycle streamed program start |
| prog_addr | output | 22 | Captured program address |
| prog_data | output | 16 | Captured program data |
| id_rdata | output | 16 | Identification read word |

## Verification
The directed patterns cover every legal command sequence once. They also include a wrong second write, a wrong third address, and an unknown command byte, which show apart the paths that return to read mode and those that advance. Random upper address and data bits on every write show that the comparisons look only at the low fields. In identification mode, the bench sends a command sequence that should be ignored, exits once through the one-write reset and once through the three-write reset, and reads all four low read-address values. A constrained random stream then mixes prefix fragments, command bytes, toggling prog_en and busy periods, and checks every write against a reference model in the bench.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;

  localparam int CMP_AW = 11;
  localparam int CMP_DW = 8;

  localparam logic [CMP_AW-1:0] KEY1_ADDR = 11'h555;
  localparam logic [CMP_AW-1:0] KEY2_ADDR = 11'h2AA;
  localparam logic [CMP_DW-1:0] KEY1_DATA = 8'hAA;
  localparam logic [CMP_DW-1:0] KEY2_DATA = 8'h55;
  localparam logic [CMP_DW-1:0] OP_RESET  = 8'hF0;
  localparam logic [CMP_DW-1:0] OP_IDENT  = 8'h90;
  localparam logic [CMP_DW-1:0] OP_WORD   = 8'hA0;
  localparam logic [CMP_DW-1:0] OP_STREAM = 8'h20;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_UNL1  = 3'd1,
    ST_UNL2  = 3'd2,
    ST_ARMED = 3'd3,
    ST_ID    = 3'd4,
    ST_IDU1  = 3'd5,
    ST_IDU2  = 3'd6
  } dec_state_t;

  typedef struct packed {
    logic key1;
    logic key2;
    logic at_cmd_addr;
    logic op_reset;
    logic op_ident;
    logic op_word;
    logic op_stream;
  } match_t;

endpackage

// File: rtl/otp_rst_sync.sv
module otp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/otp_cmd_match.sv
module otp_cmd_match
  import otp_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output match_t            m
);
  logic [CMP_AW-1:0] a_lo;
  logic [CMP_DW-1:0] d_lo;

  assign a_lo = addr[CMP_AW-1:0];
  assign d_lo = data[CMP_DW-1:0];

  always_comb begin
    m.key1        = (a_lo == KEY1_ADDR) && (d_lo == KEY1_DATA);
    m.key2        = (a_lo == KEY2_ADDR) && (d_lo == KEY2_DATA);
    m.at_cmd_addr = (a_lo == KEY1_ADDR);
    m.op_reset    = (d_lo == OP_RESET);
    m.op_ident    = (d_lo == OP_IDENT);
    m.op_word     = (d_lo == OP_WORD);
    m.op_stream   = (d_lo == OP_STREAM);
  end
endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
  import otp_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_stb,
  input  logic   prog_en,
  input  logic   eng_busy,
  input  match_t m,
  output logic   capture,
  output logic   read_mode,
  output logic   id_mode,
  output logic   word_go,
  output logic   multi_go
);
  dec_state_t st_q, st_d;
  logic       word_d, multi_d;
  logic       live_wr;

  assign live_wr = wr_stb && !eng_busy;

  always_comb begin
    st_d    = st_q;
    word_d  = 1'b0;
    multi_d = 1'b0;
    if (live_wr) begin
      if (!prog_en) begin
        if (st_q == ST_ARMED) st_d = ST_READ;
      end else begin
        unique case (st_q)
          ST_READ:  if (m.key1) st_d = ST_UNL1;
          ST_UNL1:  st_d = m.key2 ? ST_UNL2 : ST_READ;
          ST_UNL2: begin
            st_d = ST_READ;
            if (m.at_cmd_addr) begin
              if (m.op_ident)       st_d = ST_ID;
              else if (m.op_word)   st_d = ST_ARMED;
              else if (m.op_stream) multi_d = 1'b1;
            end
          end
          ST_ARMED: begin
            st_d   = ST_READ;
            word_d = 1'b1;
          end
          ST_ID: begin
            if (m.op_reset)  st_d = ST_READ;
            else if (m.key1) st_d = ST_IDU1;
          end
          ST_IDU1: begin
            if (m.op_reset)  st_d = ST_READ;
            else if (m.key2) st_d = ST_IDU2;
            else             st_d = ST_ID;
          end
          ST_IDU2: st_d = m.op_reset ? ST_READ : ST_ID;
          default: st_d = ST_READ;
        endcase
      end
    end
  end

  assign capture = word_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_READ;
      read_mode <= 1'b1;
      id_mode   <= 1'b0;
      word_go   <= 1'b0;
      multi_go  <= 1'b0;
    end else begin
      st_q      <= st_d;
      read_mode <= (st_d == ST_READ);
      id_mode   <= (st_d == ST_ID) || (st_d == ST_IDU1) || (st_d == ST_IDU2);
      word_go   <= word_d;
      multi_go  <= multi_d;
    end
  end
endmodule

// File: rtl/otp_prog_latch.sv
module otp_prog_latch #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/otp_id_codes.sv
module otp_id_codes #(
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h888A
) (
  input  logic              id_mode,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (id_mode) begin
      unique case (sel)
        2'b00:   rdata = DATA_W'(MFR_CODE);
        2'b01:   rdata = DATA_W'(DEV_CODE);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_cmd_decoder.sv
module otp_cmd_decoder
  import otp_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 22,
  parameter int          DATA_W   = 16,
  parameter int          RST_SYNC = 2,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h888A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_en,
  input  logic              eng_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              read_mode,
  output logic              id_mode,
  output logic              start_word_prog,
  output logic              start_multi_prog,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] id_rdata
);
  logic   rst_n_i;
  match_t m;
  logic   capture;

  otp_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  otp_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr(wr_addr), .data(wr_data), .m(m)
  );

  otp_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_i), .wr_stb(wr_stb), .prog_en(prog_en),
    .eng_busy(eng_busy), .m(m), .capture(capture),
    .read_mode(read_mode), .id_mode(id_mode),
    .word_go(start_word_prog), .multi_go(start_multi_prog)
  );

  otp_prog_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n_i), .capture(capture),
    .addr_in(wr_addr), .data_in(wr_data),
    .addr_q(prog_addr), .data_q(prog_data)
  );

  otp_id_codes #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .id_mode(id_mode), .sel(rd_addr[1:0]), .rdata(id_rdata)
  );
endmodule

// File: rtl/otp_cmd_decoder_chk.sv
module otp_cmd_decoder_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prog_en,
  input logic              eng_busy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              read_mode,
  input logic              id_mode,
  input logic              start_word_prog,
  input logic              start_multi_prog,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic [DATA_W-1:0] id_rdata
);
  // R2: the two mode flags are never high together
  a_r2_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(read_mode && id_mode));

  // R7: word start lasts a single cycle
  a_r7_word_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_word_prog |=> !start_word_prog);

  // R8: streamed start lasts one cycle and leaves read mode
  a_r8_multi_read: assert property (@(posedge clk) disable iff (!rst_n)
    start_multi_prog |-> (read_mode && !id_mode));

  a_r8_multi_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_multi_prog |=> !start_multi_prog);

  // R9: identification mode holds without writes
  a_r9_id_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && !wr_stb) |=> id_mode);

  // R10: identification words
  a_r10_id_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr[1:0] == 2'b01) |-> (id_rdata == 16'h888A));

  a_r10_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (id_rdata == '0));

  // R11: writes without enable start nothing
  a_r11_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !prog_en) |=> (!start_word_prog && !start_multi_prog));

  // R12: busy engine freezes the decoder
  a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> ($stable(read_mode) && $stable(id_mode) &&
                  !start_word_prog && !start_multi_prog));
endmodule

bind otp_cmd_decoder otp_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_otp_cmd_decoder.sv
`timescale 1ns/1ps
module sim_otp_cmd_decoder;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          prog_en;
  logic          eng_busy;
  logic [AW-1:0] rd_addr;
  logic          read_mode, id_mode, start_word_prog, start_multi_prog;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic [DW-1:0] id_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state: 0 read, 1/2 prefix, 3 armed, 4 id, 5/6 id prefix
  int            ms = 0;
  bit            e_word, e_multi;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_data;

  always #2.5 clk = ~clk;

  otp_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_en(prog_en), .eng_busy(eng_busy), .rd_addr(rd_addr),
    .read_mode(read_mode), .id_mode(id_mode), .start_word_prog(start_word_prog),
    .start_multi_prog(start_multi_prog), .prog_addr(prog_addr), .prog_data(prog_data),
    .id_rdata(id_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] id_expect(input bit idm, input logic [1:0] s);
    if (!idm) return 16'h0;
    if (s == 2'b00) return 16'h0020;
    if (s == 2'b01) return 16'h888A;
    return 16'h0;
  endfunction

  task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit en, input bit bz);
    bit k1, k2, ca;
    logic [7:0] c;
    k1 = (a[10:0] == 11'h555) && (d[7:0] == 8'hAA);
    k2 = (a[10:0] == 11'h2AA) && (d[7:0] == 8'h55);
    ca = (a[10:0] == 11'h555);
    c  = d[7:0];
    e_word = 0; e_multi = 0;
    if (bz) return;
    if (!en) begin
      if (ms == 3) ms = 0;
      return;
    end
    case (ms)
      0: if (k1) ms = 1;
      1: ms = k2 ? 2 : 0;
      2: begin
        ms = 0;
        if (ca && c == 8'h90) ms = 4;
        else if (ca && c == 8'hA0) ms = 3;
        else if (ca && c == 8'h20) e_multi = 1;
      end
      3: begin ms = 0; e_word = 1; e_addr = a; e_data = d; end
      4: if (c == 8'hF0) ms = 0; else if (k1) ms = 5;
      5: if (c == 8'hF0) ms = 0; else if (k2) ms = 6; else ms = 4;
      6: ms = (c == 8'hF0) ? 0 : 4;
      default: ms = 0;
    endcase
  endtask

  task automatic wr(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit en = 1, input bit bz = 0);
    @(negedge clk);
    wr_stb = 1; wr_addr = a; wr_data = d; prog_en = en; eng_busy = bz;
    model(a, d, en, bz);
    @(negedge clk);
    wr_stb = 0; eng_busy = 0; prog_en = 1;
    chk({req, " read_mode"}, 32'(read_mode), 32'(ms == 0));
    chk({req, " id_mode"}, 32'(id_mode), 32'(ms >= 4));
    chk({req, " start_word_prog"}, 32'(start_word_prog), 32'(e_word));
    chk({req, " start_multi_prog"}, 32'(start_multi_prog), 32'(e_multi));
    if (e_word) begin
      chk({req, " prog_addr"}, 32'(prog_addr), 32'(e_addr));
      chk({req, " prog_data"}, 32'(prog_data), 32'(e_data));
    end
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a);
    rd_addr = a;
    #1;
    chk(req, 32'(id_rdata), 32'(id_expect(ms >= 4, a[1:0])));
  endtask

  function automatic logic [AW-1:0] hi(input logic [10:0] lo);
    return {11'($urandom), lo};
  endfunction

  function automatic logic [DW-1:0] hd(input logic [7:0] lo);
    return {8'($urandom), lo};
  endfunction

  task automatic unlock(input string req);
    wr(req, hi(11'h555), hd(8'hAA));
    wr(req, hi(11'h2AA), hd(8'h55));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; wr_stb = 0; wr_addr = '0; wr_data = '0;
    prog_en = 1; eng_busy = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 read_mode", 32'(read_mode), 32'd1);
    chk("R1 id_mode", 32'(id_mode), 32'd0);
    chk("R1 starts", 32'({start_word_prog, start_multi_prog}), 32'd0);

    // R2 R7 R6 word program with random upper bits
    unlock("R2");
    wr("R3", hi(11'h555), hd(8'hA0));
    wr("R7", 22'h3ABCDE, 16'h5A3C);
    // R8 streamed launch
    unlock("R2");
    wr("R8", hi(11'h555), hd(8'h20));
    // R4 breaks: wrong second write, wrong command address, unknown byte
    wr("R4", hi(11'h555), hd(8'hAA));
    wr("R4", hi(11'h2AB), hd(8'h55));
    unlock("R4");
    wr("R4", hi(11'h554), hd(8'hA0));
    unlock("R4");
    wr("R4", hi(11'h555), hd(8'h77));
    // R5 single reset mid-prefix
    wr("R5", hi(11'h555), hd(8'hAA));
    wr("R5", 22'h123456, 16'h00F0);
    // R11 program abandoned without enable
    unlock("R11");
    wr("R11", hi(11'h555), hd(8'hA0));
    wr("R11", 22'h000111, 16'h0000, 0);
    wr("R11", hi(11'h555), hd(8'hAA), 0);
    // R9 R10 identification mode
    unlock("R9");
    wr("R9", hi(11'h555), hd(8'h90));
    for (int s = 0; s < 4; s++) rd_check("R10", hi(11'(s)));
    unlock("R9");
    wr("R9", hi(11'h555), hd(8'hA0));
    wr("R9", 22'h000010, 16'h1234);
    // R12 busy blocks a reset in identification mode
    wr("R12", hi(11'h000), hd(8'hF0), 1, 1);
    rd_check("R10", 22'h000001);
    // R9 three-write exit
    unlock("R9");
    wr("R9", hi(11'h555), hd(8'hF0));
    rd_check("R10", 22'h000000);
    // R9 single-write exit
    unlock("R9");
    wr("R9", hi(11'h555), hd(8'h90));
    wr("R9", hi(11'h7FF), hd(8'hF0));

    // constrained random stream
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      r = int'($urandom % 10);
      a = AW'($urandom); d = DW'($urandom);
      case (r)
        0, 1, 2: begin a = hi(11'h555); d = hd(8'hAA); end
        3, 4:    begin a = hi(11'h2AA); d = hd(8'h55); end
        5, 6: begin
          a = hi(11'h555);
          case ($urandom % 5)
            0: d = hd(8'hF0);
            1: d = hd(8'h90);
            2: d = hd(8'hA0);
            3: d = hd(8'h20);
            default: d = hd(8'h33);
          endcase
        end
        7: d = hd(8'hF0);
        default: ;
      endcase
      wr("R3 R6 random", a, d, ($urandom % 10) != 0, ($urandom % 10) == 0);
      if (i % 16 == 0) rd_check("R10 random", AW'($urandom));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule